// File: doc/BRIEF.md
# PME Root Status Tracker

This block holds the power-management-event (PME) status of one PCI Express root port. Each incoming event carries a 16-bit requestor ID. The first event sets a status flag and latches its ID. Events that arrive while that flag is still set wait in a small ordered queue, and a pending flag shows that the queue holds something. Software reads a 32-bit status word. It acknowledges the current event by writing 1 to the status bit. If the queue holds an event, the block then takes one clock to re-deliver the next queued ID.

Every transition of the status flag drives two paths. One is a level interrupt. The other is a pair of one-cycle request pulses, one asking for an upstream assert-GPE message and one asking for a deassert-GPE message. Each path has its own enable input. Message decode, configuration address decode and packet building are outside this block.

Top module: `pme_root_tracker`

## Requirements
- R1: After reset the status word reads all zeros. Its bits 31:18 always read 0. The requestor ID is in bits 15:0, the status flag in bit 16 and the pending flag in bit 17.
- R2: An event that arrives while the status flag is 0 and no re-delivery is in progress sets bit 16 and loads its ID into bits 15:0 on the next clock.
- R3: An event that arrives while the status flag is set, or while a re-delivery is in progress, is queued. Bits 15:0 do not change.
- R4: A write with bit 16 = 1 while the status flag is set clears the flag. A write with bit 16 = 0 changes nothing. Writes never alter bits 17 or 15:0 directly.
- R5: A clear with events queued makes bit 16 read 0 for exactly one cycle. On the following clock bit 16 reads 1 again, with the oldest queued ID in bits 15:0, so queued events come out in arrival order.
- R6: Bit 17 reads 1 exactly while the queue holds at least one event.
- R7: While irq_en is 1, a 0-to-1 change of the status flag sets irq and a 1-to-0 change clears it. irq is updated in the same cycle as the flag.
- R8: While gpe_en is 1, a 0-to-1 change of the status flag gives a one-cycle gpe_assert pulse and a 1-to-0 change gives a one-cycle gpe_deassert pulse. Each pulse appears in the same cycle as the flag change.
- R9: The queue holds 4 IDs. A queued event that finds the queue full, with no entry leaving in that cycle, is dropped. It then raises overflow for one cycle and leaves the state unchanged.
- R10: When an event and a clear fall in the same cycle, the clear is applied first. With the queue empty, the event is loaded directly: bit 16 stays 1, the new ID appears, and there is no edge. With the queue non-empty, the event is queued behind the earlier ones.
- R11: A flag transition that happens while an enable is 0 causes nothing on that enable's outputs. Setting the enable later does not replay the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | An incoming PME event is present this cycle |
| evt_rid | input | 16 | Requestor ID of the incoming event |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; only bit 16 acts, as write-one-to-clear |
| irq_en | input | 1 | Interrupt path enable |
| gpe_en | input | 1 | GPE message path enable |
| status_word | output | 32 | Register read value |
| irq | output | 1 | Level interrupt |
| gpe_assert | output | 1 | One-cycle request for an assert-GPE message |
| gpe_deassert | output | 1 | One-cycle request for a deassert-GPE message |
| overflow | output | 1 | One-cycle flag for a dropped event |

## Verification
The event input and the software clear can meet in one clock. The outcome then depends on the queue: with the queue empty, the event replaces the ID without any edge. With the queue non-empty, it joins the tail and a re-delivery gap follows. Directed sequences force both cases. A long random phase also produces them, along with collisions against the re-delivery cycle and against a full queue. A behavioural queue model in the bench judges every cycle field by field. The pulses and the interrupt level are checked against the flag edges the model predicts.

// File: rtl/pme_pkg.sv
package pme_pkg;

    localparam int RID_W      = 16;
    localparam int WORD_W     = 32;
    localparam int STS_BIT    = 16;
    localparam int RSVD_W     = WORD_W - RID_W - 2;
    localparam int QUEUE_DEPTH = 4;

    typedef logic [RID_W-1:0] rid_t;

    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic              pend;
        logic              sts;
        rid_t              rid;
    } pme_word_t;

    function automatic pme_word_t make_word(input logic pend, input logic sts, input rid_t rid);
        pme_word_t w;
        w.rsvd = '0;
        w.pend = pend;
        w.sts  = sts;
        w.rid  = rid;
        return w;
    endfunction

endpackage

// File: rtl/pme_rid_queue.sv
module pme_rid_queue #(
    parameter int DEPTH = pme_pkg::QUEUE_DEPTH,
    parameter int W     = pme_pkg::RID_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_req,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         not_empty,
    output logic         drop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept    = push_req && ((cnt != FULL_CNT) || pop);
    assign drop      = push_req && !accept;
    assign head      = mem[rd_ptr];
    assign not_empty = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (accept) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            cnt <= cnt + CNT_W'(accept) - CNT_W'(pop);
        end
    end

    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> not_empty);
    a_r9_drop_only_full: assert property (@(posedge clk) disable iff (rst)
        drop |-> (cnt == FULL_CNT && !pop));
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

endmodule

// File: rtl/pme_status_core.sv
module pme_status_core
    import pme_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt_valid,
    input  rid_t evt_rid,
    input  logic clr_req,
    input  rid_t q_head,
    input  logic q_not_empty,
    output logic q_push,
    output logic q_pop,
    output logic sts_q,
    output logic sts_nxt,
    output rid_t rid_q
);
    logic redel_q, redel_nxt;
    logic clr;
    rid_t rid_nxt;

    assign clr   = clr_req && sts_q;
    assign q_pop = redel_q;

    always_comb begin
        sts_nxt   = sts_q;
        rid_nxt   = rid_q;
        redel_nxt = 1'b0;
        q_push    = 1'b0;
        if (redel_q) begin
            sts_nxt = 1'b1;
            rid_nxt = q_head;
        end
        if (clr) begin
            sts_nxt   = 1'b0;
            redel_nxt = q_not_empty;
        end
        if (evt_valid) begin
            if (!sts_nxt && !redel_nxt) begin
                sts_nxt = 1'b1;
                rid_nxt = evt_rid;
            end else begin
                q_push = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q   <= 1'b0;
            rid_q   <= '0;
            redel_q <= 1'b0;
        end else begin
            sts_q   <= sts_nxt;
            rid_q   <= rid_nxt;
            redel_q <= redel_nxt;
        end
    end

    a_r2_load_idle: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !sts_q && !redel_q) |=> (sts_q && rid_q == $past(evt_rid)));
    a_r4_hold_without_clear: assert property (@(posedge clk) disable iff (rst)
        (sts_q && !clr_req) |=> sts_q);
    a_r5_gap_then_set: assert property (@(posedge clk) disable iff (rst)
        redel_q |=> sts_q);
    a_r5_gap_visible: assert property (@(posedge clk) disable iff (rst)
        redel_q |-> !sts_q);
    a_r3_busy_keeps_id: assert property (@(posedge clk) disable iff (rst)
        (sts_q && !clr_req) |=> $stable(rid_q));

endmodule

// File: rtl/pme_edge_out.sv
module pme_edge_out (
    input  logic clk,
    input  logic rst,
    input  logic sts_q,
    input  logic sts_nxt,
    input  logic irq_en,
    input  logic gpe_en,
    output logic irq,
    output logic gpe_assert,
    output logic gpe_deassert
);
    logic rise, fall;

    assign rise = sts_nxt && !sts_q;
    assign fall = !sts_nxt && sts_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq          <= 1'b0;
            gpe_assert   <= 1'b0;
            gpe_deassert <= 1'b0;
        end else begin
            if (irq_en && rise) irq <= 1'b1;
            else if (irq_en && fall) irq <= 1'b0;
            gpe_assert   <= gpe_en && rise;
            gpe_deassert <= gpe_en && fall;
        end
    end

    a_r8_pulse_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gpe_assert, gpe_deassert}));
    a_r11_irq_frozen: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> $stable(irq));
    a_r11_gpe_silent: assert property (@(posedge clk) disable iff (rst)
        !gpe_en |=> (!gpe_assert && !gpe_deassert));
    a_r8_single_cycle: assert property (@(posedge clk) disable iff (rst)
        gpe_assert |=> !gpe_assert);

endmodule

// File: rtl/pme_root_tracker.sv
module pme_root_tracker
    import pme_pkg::*;
#(
    parameter int DEPTH = QUEUE_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [RID_W-1:0]  evt_rid,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              irq_en,
    input  logic              gpe_en,
    output logic [WORD_W-1:0] status_word,
    output logic              irq,
    output logic              gpe_assert,
    output logic              gpe_deassert,
    output logic              overflow
);
    logic      q_push, q_pop, q_not_empty, q_drop;
    rid_t      q_head, rid_q;
    logic      sts_q, sts_nxt;
    logic      clr_req;
    pme_word_t word;
    logic      unused_wr_bits;

    assign clr_req        = wr_en && wr_data[STS_BIT];
    assign unused_wr_bits = ^{wr_data[WORD_W-1:STS_BIT+1], wr_data[STS_BIT-1:0]};

    pme_status_core u_core (
        .clk         (clk),
        .rst         (rst),
        .evt_valid   (evt_valid),
        .evt_rid     (evt_rid),
        .clr_req     (clr_req),
        .q_head      (q_head),
        .q_not_empty (q_not_empty),
        .q_push      (q_push),
        .q_pop       (q_pop),
        .sts_q       (sts_q),
        .sts_nxt     (sts_nxt),
        .rid_q       (rid_q)
    );

    pme_rid_queue #(.DEPTH(DEPTH), .W(RID_W)) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push_req  (q_push),
        .pop       (q_pop),
        .din       (evt_rid),
        .head      (q_head),
        .not_empty (q_not_empty),
        .drop      (q_drop)
    );

    pme_edge_out u_edge (
        .clk          (clk),
        .rst          (rst),
        .sts_q        (sts_q),
        .sts_nxt      (sts_nxt),
        .irq_en       (irq_en),
        .gpe_en       (gpe_en),
        .irq          (irq),
        .gpe_assert   (gpe_assert),
        .gpe_deassert (gpe_deassert)
    );

    always_ff @(posedge clk) begin
        if (rst) overflow <= 1'b0;
        else     overflow <= q_drop;
    end

    assign word        = make_word(q_not_empty, sts_q, rid_q);
    assign status_word = word;

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        status_word[WORD_W-1:STS_BIT+2] == '0);
    a_r9_overflow_pulse: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(evt_valid));
    a_r4_rid_ro: assert property (@(posedge clk) disable iff (rst)
        (!evt_valid && !sts_q && !q_not_empty) |=> $stable(status_word[RID_W-1:0]));

endmodule

// File: tb/tb_pme_root_tracker.sv
module tb_pme_root_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [15:0] evt_rid = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        irq_en = 1'b0;
    logic        gpe_en = 1'b0;
    logic [31:0] status_word;
    logic        irq, gpe_assert, gpe_deassert, overflow;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit done = 0;

    // behavioural reference
    bit          m_sts, m_redel, m_irq, m_ga, m_gd, m_ovf;
    logic [15:0] m_rid;
    logic [15:0] m_q[$];

    pme_root_tracker dut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_rid(evt_rid),
        .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en), .gpe_en(gpe_en),
        .status_word(status_word), .irq(irq), .gpe_assert(gpe_assert),
        .gpe_deassert(gpe_deassert), .overflow(overflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(status_word[31:18] == 14'd0, "R1", "reserved", {18'd0, status_word[31:18]}, 32'd0);
        chk(status_word[16] == m_sts, {cur_req, "/R5"}, "status", {31'd0, status_word[16]}, {31'd0, m_sts});
        chk(status_word[15:0] == m_rid, {cur_req, "/R2"}, "rid", {16'd0, status_word[15:0]}, {16'd0, m_rid});
        chk(status_word[17] == (m_q.size() != 0), {cur_req, "/R6"}, "pending",
            {31'd0, status_word[17]}, {31'd0, m_q.size() != 0});
        chk(irq == m_irq, {cur_req, "/R7"}, "irq", {31'd0, irq}, {31'd0, m_irq});
        chk(gpe_assert == m_ga, {cur_req, "/R8"}, "gpe_assert", {31'd0, gpe_assert}, {31'd0, m_ga});
        chk(gpe_deassert == m_gd, {cur_req, "/R8"}, "gpe_deassert", {31'd0, gpe_deassert}, {31'd0, m_gd});
        chk(overflow == m_ovf, {cur_req, "/R9"}, "overflow", {31'd0, overflow}, {31'd0, m_ovf});
    endtask

    task automatic do_reset();
        rst = 1'b1; evt_valid = 1'b0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_sts = 0; m_redel = 0; m_irq = 0; m_ga = 0; m_gd = 0; m_ovf = 0;
        m_rid = '0; m_q.delete();
        cur_req = "R1";
        compare_all();
    endtask

    task automatic cyc(input bit ev, input logic [15:0] rid, input bit wr, input logic [31:0] wd);
        bit nsts, nredel, clr, rise, fall;
        logic [15:0] nrid;
        evt_valid = ev; evt_rid = rid; wr_en = wr; wr_data = wd;
        nsts = m_sts; nrid = m_rid; nredel = 0; m_ovf = 0;
        clr = wr && wd[16] && m_sts;
        if (m_redel) begin
            nsts = 1;
            nrid = m_q.pop_front();
        end
        if (clr) begin
            nsts = 0;
            nredel = (m_q.size() != 0);
        end
        if (ev) begin
            if (!nsts && !nredel) begin
                nsts = 1; nrid = rid;
            end else if (m_q.size() < QDEPTH) m_q.push_back(rid);
            else m_ovf = 1;
        end
        rise = nsts && !m_sts;
        fall = !nsts && m_sts;
        if (irq_en && rise) m_irq = 1;
        else if (irq_en && fall) m_irq = 0;
        m_ga = gpe_en && rise;
        m_gd = gpe_en && fall;
        m_sts = nsts; m_rid = nrid; m_redel = nredel;
        @(posedge clk);
        #1;
        evt_valid = 1'b0; wr_en = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 16'h0, 0, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        irq_en = 1; gpe_en = 1;
        // R1: writes while idle leave the word at zero
        cur_req = "R1";  cyc(0, 0, 1, 32'hFFFF_FFFF);
        // R2: load into idle status
        cur_req = "R2";  cyc(1, 16'hA1B2, 0, 0); idle(1);
        // R3: queue behind a set status, ID unchanged
        cur_req = "R3";
        for (int i = 0; i < 4; i++) cyc(1, 16'h0100 + 16'(i), 0, 0);
        // R9: fifth queued event is dropped
        cur_req = "R9";  cyc(1, 16'hDEAD, 0, 0); idle(1);
        // R4: write with bit 16 at zero, all others set
        cur_req = "R4";  cyc(0, 0, 1, 32'hFFFE_FFFF); idle(1);
        // R5: clears re-deliver queued IDs in order, R6 pending falls at the end
        cur_req = "R5";
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 1, 32'h0001_0000); idle(2);
        end
        cur_req = "R6";  cyc(0, 0, 1, 32'h0001_0000); idle(2);
        // R10: clear and event together, queue empty then non-empty
        cur_req = "R10";
        cyc(1, 16'h1111, 0, 0);
        cyc(1, 16'h2222, 1, 32'h0001_0000); idle(1);
        cyc(1, 16'h3333, 0, 0);
        cyc(1, 16'h4444, 1, 32'h0001_0000);
        cyc(1, 16'h5555, 0, 0); idle(2);
        cyc(0, 0, 1, 32'h0001_0000); idle(2);
        cyc(0, 0, 1, 32'h0001_0000); idle(2);
        // R11: transitions with enables low, then enables raised
        cur_req = "R11";
        irq_en = 0; gpe_en = 0;
        cyc(1, 16'h7777, 0, 0); idle(1);
        irq_en = 1; gpe_en = 1; idle(3);
        irq_en = 0; gpe_en = 0;
        cyc(0, 0, 1, 32'h0001_0000); idle(1);
        irq_en = 1; gpe_en = 1; idle(3);
        cyc(1, 16'h8888, 0, 0); idle(1);
        // R7 and R8 under mixed random traffic
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 50) == 0) irq_en = $urandom % 2;
            if (($urandom % 50) == 0) gpe_en = $urandom % 2;
            cyc(($urandom % 10) < 4, 16'($urandom), ($urandom % 10) < 3,
                {$urandom} ^ (($urandom % 2) ? 32'h0001_0000 : 32'h0));
        end
        cur_req = "R1";
        do_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule